// File: doc/BRIEF.md
# Holdover Pulse-Per-Second Generator

This block produces the system's once-per-second timing pulse by dividing a free-running reference clock (122.88 MHz by default) with a counter. The pulse train never stops and never jumps on its own. A satellite timing receiver supplies its own pulse and a separate lock-good flag. The block measures the phase of the receiver pulse against its local count and may realign the local count to that pulse, but only when the receiver reports lock and its pulse has been arriving regularly.

Receiver pulses are tracked by a timeout. When no rising edge has arrived for a programmable span (1.5 s by default), the reference is declared invalid and the local pulse simply free-runs (holdover). When pulses return, the first edge only re-establishes trust. A later edge, seen while lock is reported, can jam-sync the counter if the measured error is larger than a programmable threshold. Realignment is allowed once after start-up or after any loss of lock or reference, and after that only once every `CHECK_SECS` local seconds.

The signed phase error and a one-cycle adjust strobe are offered on status outputs. A holdover flag shows whether the local pulse is currently running without a trusted reference.

Top module: `pps_holdover_gen`

## Requirements
- R1: The local count runs 0 to CNT_PER_SEC-1 and wraps to 0. Without a jam, `pps_o` rises exactly every CNT_PER_SEC cycles, and this holds whether or not a reference is present.
- R2: `pps_o` is high while the local count is below `pulse_len_i`, so the pulse starts at the wrap and lasts `pulse_len_i` cycles. A length of 0 gives no pulse.
- R3: `ref_pps_i` passes through SYNC_STAGES flops and only its rising edge is used. An edge driven while the local count is c is measured as raw value (c + SYNC_STAGES) mod CNT_PER_SEC.
- R4: `phase_err_o` is the two's-complement raw value folded so that raw values at or above CNT_PER_SEC/2 read as raw minus CNT_PER_SEC. It is updated only on a reference edge seen while `lock_ok_i` is 1 and is held otherwise.
- R5: `ref_valid_o` goes to 1 on any reference edge. It falls MISS_LIMIT cycles after the cycle that consumed the last edge if no further edge arrives.
- R6: At a reference edge where `lock_ok_i`, `ref_valid_o` (its value before the edge) and the check window are all 1, and |error| > `jam_thresh_i`, the count is reloaded so that an aligned next reference reads error 0. `adjust_o` pulses high for one cycle in that case. An error equal to or below the threshold causes no jam.
- R7: The check window is open after reset and whenever lock or reference validity is low. A check (an edge meeting the R6 conditions apart from the threshold) closes the window. It reopens after CHECK_SECS local wraps.
- R8: The first reference edge after the reference was invalid never causes a jam, whatever its error.
- R9: In reset, `pps_o`, `ref_valid_o`, `adjust_o` and `phase_err_o` are 0. `holdover_o` is 1 whenever `lock_ok_i` or `ref_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, CNT_PER_SEC cycles per second |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_pps_i | input | 1 | Receiver pulse, asynchronous |
| lock_ok_i | input | 1 | Receiver reports a good fix |
| jam_thresh_i | input | CW | Largest error magnitude tolerated without a jam |
| pulse_len_i | input | CW | Output pulse length in cycles |
| pps_o | output | 1 | Local once-per-second pulse |
| ref_valid_o | output | 1 | Receiver pulses arriving within the timeout |
| holdover_o | output | 1 | Local pulse running without a trusted reference |
| adjust_o | output | 1 | One-cycle strobe when the count was jam-synced |
| phase_err_o | output | CW+1 | Last measured signed phase error in cycles |

## Verification
The main function is driven with reference edges placed at chosen local counts. These include a small error that sits inside, at and just beyond the threshold, both fold boundaries, and large positive and negative offsets. Together they separate the fold arithmetic from the threshold compare and show that the reload makes the next aligned edge read zero. Edges sent with lock low, edges sent one second after a check, and the first edge after a timeout tell the three gating conditions apart. Long gaps with no edges show that the timeout and the holdover period are independent of the reference.

// File: rtl/pps_hold_pkg.sv
// Package: shared defaults for the holdover pulse generator.
// Assumes a 122.88 MHz reference clock; integrators may use these
// constants to drive the programmable inputs at start-up.
package pps_hold_pkg;
    localparam int unsigned REF_HZ_DEF     = 122_880_000;
    localparam int unsigned MISS_CYC_DEF   = 184_320_000;
    localparam int unsigned PULSE_CYC_DEF  = 12_288_000;
    localparam int unsigned CHECK_SECS_DEF = 16;
    localparam int unsigned SYNC_DEF       = 2;
endpackage

// File: rtl/pps_ref_sync.sv
// Module: pps_ref_sync
// Brings the asynchronous receiver pulse into the clock domain through
// STAGES flops and emits a one-cycle strobe on its rising edge.
// Assumes the receiver pulse stays high for at least two clock cycles.
module pps_ref_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sh_q;
    logic              last_q;

    // Shift the raw input through the synchronizer chain and keep the prior output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            last_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], async_i};
            last_q <= sh_q[STAGES-1];
        end
    end

    assign rise_o = sh_q[STAGES-1] & ~last_q;

    // A single edge yields one strobe, never two in a row.
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/pps_sec_counter.sv
// Module: pps_sec_counter
// Free-running once-per-second counter with a jam-load input and the
// pulse shaper. Assumes jam_i is a one-cycle request; the load value 1
// accounts for the cycle in which the request is consumed.
module pps_sec_counter #(
    parameter  int unsigned CNT_PER_SEC = 122_880_000,
    localparam int          CW          = $clog2(CNT_PER_SEC)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          jam_i,
    input  logic [CW-1:0] pulse_len_i,
    output logic [CW-1:0] cnt_o,
    output logic          wrap_o,
    output logic          pps_o
);
    localparam logic [CW-1:0] LAST    = CW'(CNT_PER_SEC - 1);
    localparam logic [CW-1:0] JAM_VAL = CW'(1);

    logic [CW-1:0] cnt_q, cnt_nx;
    logic          pps_q;
    logic          past_ok_q;

    // Next count: reload on jam, wrap at the end of the second, else step.
    always_comb begin
        if (jam_i)              cnt_nx = JAM_VAL;
        else if (cnt_q == LAST) cnt_nx = '0;
        else                    cnt_nx = cnt_q + CW'(1);
    end

    // Register the count and a pulse that is high for the first pulse_len_i counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pps_q     <= 1'b0;
            past_ok_q <= 1'b0;
        end else begin
            cnt_q     <= cnt_nx;
            pps_q     <= (cnt_nx < pulse_len_i);
            past_ok_q <= 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign pps_o  = pps_q;
    assign wrap_o = (cnt_q == LAST) && !jam_i;

    // Count stays inside one second.
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // Without a jam the count advances by exactly one, modulo the second.
    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(jam_i)) |->
        (cnt_q == (($past(cnt_q) == LAST) ? '0 : $past(cnt_q) + CW'(1))));
    // A jam request reloads the count.
    p_jam_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        jam_i |=> (cnt_q == JAM_VAL));
endmodule

// File: rtl/pps_ref_watch.sv
// Module: pps_ref_watch
// Timeout on the receiver pulse: any edge marks the reference valid,
// and LIMIT cycles without an edge mark it invalid. The timer saturates.
module pps_ref_watch #(
    parameter  int unsigned LIMIT = 184_320_000,
    localparam int          TW    = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic valid_o
);
    localparam logic [TW-1:0] LIM = TW'(LIMIT);

    logic [TW-1:0] tmr_q;
    logic          valid_q;

    // Restart the timer on an edge; drop validity when it reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q   <= LIM;
            valid_q <= 1'b0;
        end else if (rise_i) begin
            tmr_q   <= '0;
            valid_q <= 1'b1;
        end else if (tmr_q != LIM) begin
            tmr_q <= tmr_q + TW'(1);
            if (tmr_q == LIM - TW'(1)) valid_q <= 1'b0;
        end
    end

    assign valid_o = valid_q;

    // An edge always makes the reference valid.
    p_valid_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> valid_q);
    // Validity is lost only when the full timeout has elapsed.
    p_valid_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_q) |-> (tmr_q == LIM));
endmodule

// File: rtl/pps_phase_check.sv
// Module: pps_phase_check
// Folds the local count seen at a reference edge into a signed error,
// keeps the last locked measurement, and decides on a jam-sync. The
// check window opens after CHECK_SECS local wraps or on any loss.
module pps_phase_check #(
    parameter  int unsigned CNT_PER_SEC = 122_880_000,
    parameter  int unsigned CHECK_SECS  = 16,
    localparam int          CW          = $clog2(CNT_PER_SEC),
    localparam int          EW          = CW + 1,
    localparam int          SW          = $clog2(CHECK_SECS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_i,
    input  logic          lock_i,
    input  logic          valid_i,
    input  logic          tick_i,
    input  logic [CW-1:0] cnt_i,
    input  logic [CW-1:0] thresh_i,
    output logic          jam_o,
    output logic          adj_o,
    output logic [EW-1:0] err_o
);
    localparam logic [CW-1:0] HALF     = CW'(CNT_PER_SEC / 2);
    localparam logic [EW:0]   N_X      = (EW + 1)'(CNT_PER_SEC);
    localparam logic [SW-1:0] LAST_SEC = SW'(CHECK_SECS - 1);
    localparam int            ERR_LO   = int'(CNT_PER_SEC / 2) - int'(CNT_PER_SEC);
    localparam int            ERR_HI   = int'(CNT_PER_SEC / 2) - 1;

    logic [EW:0]   wide;
    logic [EW-1:0] err_now, mag, err_q;
    logic [SW-1:0] sec_q;
    logic          armed_q, check, adj_q, past_ok_q;

    // Fold the raw count into a signed error and compare its magnitude.
    always_comb begin
        wide    = (cnt_i >= HALF) ? ({2'b00, cnt_i} - N_X) : {2'b00, cnt_i};
        err_now = wide[EW-1:0];
        mag     = err_now[EW-1] ? (~err_now + EW'(1)) : err_now;
        check   = rise_i && lock_i && valid_i && armed_q;
        jam_o   = check && (mag > {1'b0, thresh_i});
    end

    // Capture the locked measurement and the adjust strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q     <= '0;
            adj_q     <= 1'b0;
            past_ok_q <= 1'b0;
        end else begin
            if (rise_i && lock_i) err_q <= err_now;
            adj_q     <= jam_o;
            past_ok_q <= 1'b1;
        end
    end

    // Schedule the check window: open on loss, close on a check, reopen after CHECK_SECS wraps.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b1;
            sec_q   <= '0;
        end else if (!lock_i || !valid_i) begin
            armed_q <= 1'b1;
            sec_q   <= '0;
        end else if (check) begin
            armed_q <= 1'b0;
            sec_q   <= '0;
        end else if (tick_i && !armed_q) begin
            if (sec_q == LAST_SEC) armed_q <= 1'b1;
            sec_q <= sec_q + SW'(1);
        end
    end

    assign adj_o = adj_q;
    assign err_o = err_q;

    // Reported error always lies in the folded range.
    p_err_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'($signed(err_q)) >= ERR_LO) && (int'($signed(err_q)) <= ERR_HI));
    // Error is held unless a locked edge was seen.
    p_hold_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !$past(rise_i && lock_i)) |-> $stable(err_q));
    // A completed check closes the window.
    p_armed_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        check |=> !armed_q);
endmodule

// File: rtl/pps_holdover_gen.sv
// Module: pps_holdover_gen (top)
// Local once-per-second generator that free-runs through loss of the
// receiver and jam-syncs to a trusted receiver pulse. Assumes clk is the
// disciplined reference clock and lock_ok_i is already synchronous.
module pps_holdover_gen
    import pps_hold_pkg::*;
#(
    parameter  int unsigned CNT_PER_SEC = REF_HZ_DEF,
    parameter  int unsigned MISS_LIMIT  = MISS_CYC_DEF,
    parameter  int unsigned CHECK_SECS  = CHECK_SECS_DEF,
    parameter  int unsigned SYNC_STAGES = SYNC_DEF,
    localparam int          CW          = $clog2(CNT_PER_SEC),
    localparam int          EW          = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_pps_i,
    input  logic          lock_ok_i,
    input  logic [CW-1:0] jam_thresh_i,
    input  logic [CW-1:0] pulse_len_i,
    output logic          pps_o,
    output logic          ref_valid_o,
    output logic          holdover_o,
    output logic          adjust_o,
    output logic [EW-1:0] phase_err_o
);
    logic          rise, jam, wrap, valid;
    logic [CW-1:0] cnt;

    pps_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(ref_pps_i), .rise_o(rise));

    pps_ref_watch #(.LIMIT(MISS_LIMIT)) u_watch (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .valid_o(valid));

    pps_sec_counter #(.CNT_PER_SEC(CNT_PER_SEC)) u_cnt (
        .clk(clk), .rst_n(rst_n), .jam_i(jam), .pulse_len_i(pulse_len_i),
        .cnt_o(cnt), .wrap_o(wrap), .pps_o(pps_o));

    pps_phase_check #(.CNT_PER_SEC(CNT_PER_SEC), .CHECK_SECS(CHECK_SECS)) u_chk (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .lock_i(lock_ok_i),
        .valid_i(valid), .tick_i(wrap), .cnt_i(cnt), .thresh_i(jam_thresh_i),
        .jam_o(jam), .adj_o(adjust_o), .err_o(phase_err_o));

    // Status: holdover whenever the reference cannot be trusted.
    assign ref_valid_o = valid;
    assign holdover_o  = ~(lock_ok_i & valid);

    // An adjustment only ever follows a cycle with lock reported.
    p_adj_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adjust_o |-> $past(lock_ok_i));
endmodule

// File: tb/pps_holdover_gen_tb.sv
module pps_holdover_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 1000;
    localparam int MISS = 4000;
    localparam int CHK  = 2;
    localparam int CW   = $clog2(N);
    localparam int EW   = CW + 1;
    localparam int NV   = 13;

    // Vector table: ref offset after wrap, lock, threshold, expected error, expected adjust.
    localparam int V_C  [NV] = '{100, 100, 998, 1, 4, 700, 497, 498, 990, 987, 300, 300, 8};
    localparam int V_LK [NV] = '{1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 0, 1, 1};
    localparam int V_TH [NV] = '{5, 5, 5, 5, 5, 10, 10, 10, 10, 10, 0, 0, 10};
    localparam int V_ERR[NV] = '{102, 102, 0, 3, 6, -298, 499, -500, -8, -11, -11, 302, 10};
    localparam int V_ADJ[NV] = '{0, 1, 0, 0, 1, 1, 1, 1, 0, 1, 0, 1, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_pps = 1'b0;
    logic          lock = 1'b1;
    logic [CW-1:0] thresh = '0;
    logic [CW-1:0] plen = CW'(100);
    logic          pps, valid, hold, adjust;
    logic [EW-1:0] perr;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pps_holdover_gen #(.CNT_PER_SEC(N), .MISS_LIMIT(MISS), .CHECK_SECS(CHK), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_pps_i(ref_pps), .lock_ok_i(lock),
        .jam_thresh_i(thresh), .pulse_len_i(plen), .pps_o(pps),
        .ref_valid_o(valid), .holdover_o(hold), .adjust_o(adjust), .phase_err_o(perr));

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic wait_rise();
        logic prev;
        prev = pps;
        @(negedge clk);
        while (!(pps && !prev)) begin
            prev = pps;
            @(negedge clk);
        end
    endtask

    // Drive a reference edge c cycles after the next wrap; sample results when they settle.
    task automatic send_ref(input int c, output int err, output int adj);
        wait_rise();
        repeat (c) @(negedge clk);
        ref_pps = 1'b1;
        repeat (3) @(negedge clk);
        err = int'($signed(perr));
        adj = int'(adjust);
        repeat (2) @(negedge clk);
        ref_pps = 1'b0;
    endtask

    initial begin
        int e, a, n;
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 pps in reset", int'(pps), 0);
        check("R9 ref_valid in reset", int'(valid), 0);
        check("R9 adjust in reset", int'(adjust), 0);
        check("R9 phase_err in reset", int'($signed(perr)), 0);
        check("R9 holdover in reset", int'(hold), 1);
        rst_n = 1'b1;

        // Table walk: R3/R4 fold, R6 threshold and reload, R8 first edge, R9 holdover flag
        for (int i = 0; i < NV; i++) begin
            lock   = V_LK[i][0];
            thresh = CW'(V_TH[i]);
            wait_rise();
            send_ref(V_C[i], e, a);
            check($sformatf("R3 R4 vec %0d phase error", i), e, V_ERR[i]);
            check($sformatf("R6 R8 vec %0d adjust", i), a, V_ADJ[i]);
            check($sformatf("R9 vec %0d holdover", i), int'(hold), 1 - V_LK[i]);
        end

        // R7: one wrap after a check the window is closed, two wraps later it is open
        thresh = '0;
        send_ref(200, e, a);
        check("R7 closed window error", e, 202);
        check("R7 closed window no adjust", a, 0);
        send_ref(200, e, a);
        check("R7 reopened window adjust", a, 1);

        // R5: timeout of the reference
        wait_rise();
        ref_pps = 1'b1;
        repeat (5) @(negedge clk);
        ref_pps = 1'b0;
        repeat (MISS - 3) @(negedge clk);
        check("R5 valid just before timeout", int'(valid), 1);
        @(negedge clk);
        check("R5 valid after timeout", int'(valid), 0);
        check("R9 holdover after timeout", int'(hold), 1);

        // R1: holdover period stays exact
        for (int k = 0; k < 2; k++) begin
            wait_rise();
            n = 0;
            begin
                logic prev;
                do begin
                    prev = pps;
                    @(negedge clk);
                    n++;
                end while (!(pps && !prev));
            end
            check("R1 holdover period", n, N);
        end

        // R8: first edge after loss is only trusted, the next one realigns
        send_ref(50, e, a);
        check("R8 first edge error", e, 52);
        check("R8 first edge no adjust", a, 0);
        check("R5 valid after edge", int'(valid), 1);
        send_ref(50, e, a);
        check("R8 second edge adjust", a, 1);

        // R2: programmable pulse length
        while (pps) @(negedge clk);
        plen = CW'(37);
        wait_rise();
        n = 1;
        while (1) begin
            @(negedge clk);
            if (pps) n++;
            else break;
        end
        check("R2 pulse length 37", n, 37);
        plen = '0;
        n = 0;
        repeat (N + 100) begin
            @(negedge clk);
            if (pps) n++;
        end
        check("R2 zero length gives no pulse", n, 0);

        // R9: reset mid-run clears outputs
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 valid after reset", int'(valid), 0);
        check("R9 phase_err after reset", int'($signed(perr)), 0);
        check("R9 pps after reset", int'(pps), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (120000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog expired: got 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule